// File: doc/BRIEF.md
# Light-Sleep Entry and Wake Sequencer

This block decides when a processor core drops into a light sleep state and which sources are allowed to bring it back. It watches the core's wait-for-interrupt and wait-for-event requests and its exception-return strobe. It also watches three control bits: a deep-sleep select, a sleep-after-handler select and a wake-on-any-pend select. When the conditions allow, it gates the core clock and moves the mode from a run state to the matching sleep state.

On entry the sequencer records the cause: wait-for-interrupt, wait-for-event or sleep-after-handler. That cause, together with the wake-on-any-pend bit, selects the wake sources. Enabled interrupts end an interrupt-style sleep. Wakeup events end an event-style sleep. In event-style sleep with wake-on-any-pend set, any interrupt that newly becomes pending also wakes the core, enabled or not. A core that slept from low-power run resumes in low-power run. Outputs driven toward the pins are frozen for the whole sleep.

Top module: `sleep_seq_top`

## Requirements
- R1: While deep-sleep select is 1, no request (wait-for-interrupt, wait-for-event or exception return) moves the mode out of its run state.
- R2: A wait-for-interrupt request is refused while any enabled interrupt is pending. A wait-for-event request is refused while any wakeup event is pending. A refused request leaves the mode in run.
- R3: An exception-return strobe with deep-sleep select 0, sleep-after-handler select 1 and no enabled interrupt pending enters sleep. With an enabled interrupt pending it does not.
- R4: After entry by wait-for-interrupt or by exception return, only an enabled pending interrupt wakes the core. Wakeup events and disabled pending interrupts leave it asleep.
- R5: After entry by wait-for-event with wake-on-any-pend 0, only a wakeup event wakes the core. Enabled interrupts leave it asleep.
- R6: After entry by wait-for-event with wake-on-any-pend 1, a wakeup event wakes the core, and so does any interrupt whose pending bit (enabled or disabled vector) rises.
- R7: Mode encoding is run=0, sleep=1, low-power run=2, low-power sleep=3. Entry from low-power run goes to low-power sleep, entry from run goes to sleep. Waking from low-power sleep returns to low-power run whatever the low-power flag then says. Outside sleep the mode follows the low-power flag one cycle later.
- R8: The mode leaves sleep on the first clock edge after the wake condition is present. Clock enable is 0 exactly while asleep. The wake reason (1 = interrupt, 2 = event, 0 = none) is nonzero for exactly the one cycle after the waking edge.
- R9: The pin-state output captures its input each cycle outside sleep and holds its value unchanged through both sleep states.
- R10: The cause output reads 1 after wait-for-interrupt entry, 2 after wait-for-event entry and 3 after exception-return entry. It reads 0 whenever the core is not asleep.
- R11: When wait-for-interrupt and wait-for-event requests arrive in the same cycle, the entry is recorded as wait-for-interrupt.
- R12: During reset the mode is run, the cause and wake reason are 0, the clock enable is 1 and the pin-state output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_n_i | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wfi_req_i | input | 1 | Wait-for-interrupt request |
| wfe_req_i | input | 1 | Wait-for-event request |
| exc_ret_i | input | 1 | Exception-return strobe |
| deep_sel_i | input | 1 | Deep-sleep select; 1 blocks light sleep |
| sleep_after_isr_i | input | 1 | Sleep-after-handler select |
| wake_any_pend_i | input | 1 | Any newly pending interrupt counts as an event |
| lp_run_i | input | 1 | Low-power run status flag |
| irq_en_pend_i | input | N_IRQ | Pending enabled interrupts |
| irq_dis_pend_i | input | N_IRQ | Pending interrupts disabled in the controller |
| wake_evt_i | input | N_EVT | Wakeup events |
| pin_d_i | input | N_PIN | Pin state requested by the core |
| mode_o | output | 2 | Current mode (R7 encoding) |
| clk_en_o | output | 1 | Core clock-gate enable |
| cause_o | output | 2 | Recorded entry cause (R10 encoding) |
| wake_rsn_o | output | 2 | One-cycle wake reason (R8 encoding) |
| pin_q_o | output | N_PIN | Pin state held during sleep |

## Verification
On every cycle the assertions check several relations. Deep-sleep select keeps a run state in run. A sleeping core with no qualifying source stays asleep for the interrupt-style and event-only causes. The clock enable and the cause agree with the sleep bit of the mode. The low-power pairing holds on entry and on return. The wake reason is a single-cycle pulse, and the pin state stays stable through sleep. Some behaviours only the bench's scenarios can show: the refusal of a request while something is pending, the WFI-over-WFE choice, the exact cause codes and reasons on each path, the rising-edge detection of disabled interrupts under wake-on-any-pend, and the return to low-power run against a flag that has since dropped.

// File: rtl/slp_pkg.sv
package slp_pkg;

  typedef enum logic [1:0] {
    MODE_RUN     = 2'd0,
    MODE_SLEEP   = 2'd1,
    MODE_LPRUN   = 2'd2,
    MODE_LPSLEEP = 2'd3
  } mode_e;

  typedef enum logic [1:0] {
    CAUSE_NONE = 2'd0,
    CAUSE_WFI  = 2'd1,
    CAUSE_WFE  = 2'd2,
    CAUSE_SOE  = 2'd3
  } cause_e;

  typedef enum logic [1:0] {
    RSN_NONE = 2'd0,
    RSN_IRQ  = 2'd1,
    RSN_EVT  = 2'd2
  } rsn_e;

  // Bit 0 of the mode marks a sleep state, bit 1 marks low power.
  localparam int MODE_SLEEP_BIT = 0;
  localparam int MODE_LP_BIT    = 1;

endpackage

// File: rtl/slp_rst_sync.sv
module slp_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_n_i,
  output logic rst_n_o
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) sync_q <= '0;
    else          sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = sync_q[STAGES-1];
endmodule

// File: rtl/slp_entry_dec.sv
module slp_entry_dec
  import slp_pkg::*;
(
  input  logic   wfi_req_i,
  input  logic   wfe_req_i,
  input  logic   exc_ret_i,
  input  logic   deep_sel_i,
  input  logic   sleep_after_isr_i,
  input  logic   irq_pend_any_i,
  input  logic   evt_pend_any_i,
  output logic   enter_o,
  output cause_e cause_o
);
  // Fixed order: WFI first, then WFE, then the exception-return path.
  always_comb begin
    enter_o = 1'b0;
    cause_o = CAUSE_NONE;
    if (!deep_sel_i) begin
      if (wfi_req_i) begin
        enter_o = !irq_pend_any_i;
        cause_o = CAUSE_WFI;
      end else if (wfe_req_i) begin
        enter_o = !evt_pend_any_i;
        cause_o = CAUSE_WFE;
      end else if (exc_ret_i && sleep_after_isr_i) begin
        enter_o = !irq_pend_any_i;
        cause_o = CAUSE_SOE;
      end
    end
    if (!enter_o) cause_o = CAUSE_NONE;
  end
endmodule

// File: rtl/slp_wake_sel.sv
module slp_wake_sel
  import slp_pkg::*;
#(
  parameter int N_IRQ = 16,
  parameter int N_EVT = 8
) (
  input  logic             clk_i,
  input  logic             rst_n_i,
  input  cause_e           cause_i,
  input  logic             wake_any_pend_i,
  input  logic [N_IRQ-1:0] irq_en_pend_i,
  input  logic [N_IRQ-1:0] irq_dis_pend_i,
  input  logic [N_EVT-1:0] wake_evt_i,
  output logic             wake_o,
  output rsn_e             rsn_o
);
  logic [N_IRQ-1:0] pend_all;
  logic [N_IRQ-1:0] pend_q;
  logic [N_IRQ-1:0] pend_rise;
  logic             irq_any, evt_any, rise_any;

  assign pend_all  = irq_en_pend_i | irq_dis_pend_i;
  assign pend_rise = pend_all & ~pend_q;
  assign irq_any   = |irq_en_pend_i;
  assign evt_any   = |wake_evt_i;
  assign rise_any  = |pend_rise;

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) pend_q <= '0;
    else          pend_q <= pend_all;
  end

  always_comb begin
    wake_o = 1'b0;
    rsn_o  = RSN_NONE;
    unique case (cause_i)
      CAUSE_WFI, CAUSE_SOE: begin
        wake_o = irq_any;
        rsn_o  = irq_any ? RSN_IRQ : RSN_NONE;
      end
      CAUSE_WFE: begin
        if (evt_any) begin
          wake_o = 1'b1;
          rsn_o  = RSN_EVT;
        end else if (wake_any_pend_i && rise_any) begin
          wake_o = 1'b1;
          rsn_o  = RSN_IRQ;
        end
      end
      default: begin
        wake_o = 1'b0;
        rsn_o  = RSN_NONE;
      end
    endcase
  end
endmodule

// File: rtl/slp_pin_hold.sv
module slp_pin_hold #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_n_i,
  input  logic         ld_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_r, q_n;

  always_comb q_n = ld_i ? d_i : q_r;

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) q_r <= '0;
    else          q_r <= q_n;
  end

  assign q_o = q_r;
endmodule

// File: rtl/sleep_seq_top.sv
module sleep_seq_top
  import slp_pkg::*;
#(
  parameter int N_IRQ = 16,
  parameter int N_EVT = 8,
  parameter int N_PIN = 8
) (
  input  logic             clk_i,
  input  logic             rst_n_i,
  input  logic             wfi_req_i,
  input  logic             wfe_req_i,
  input  logic             exc_ret_i,
  input  logic             deep_sel_i,
  input  logic             sleep_after_isr_i,
  input  logic             wake_any_pend_i,
  input  logic             lp_run_i,
  input  logic [N_IRQ-1:0] irq_en_pend_i,
  input  logic [N_IRQ-1:0] irq_dis_pend_i,
  input  logic [N_EVT-1:0] wake_evt_i,
  input  logic [N_PIN-1:0] pin_d_i,
  output logic [1:0]       mode_o,
  output logic             clk_en_o,
  output logic [1:0]       cause_o,
  output logic [1:0]       wake_rsn_o,
  output logic [N_PIN-1:0] pin_q_o
);
  logic   rst_n_s;
  logic   enter;
  cause_e ent_cause;
  logic   wake;
  rsn_e   wake_rsn;

  mode_e  mode_q, mode_n;
  cause_e cause_q, cause_n;
  rsn_e   rsn_q, rsn_n;
  logic   clk_en_q, clk_en_n;
  logic   asleep, in_lp;

  slp_rst_sync #(.STAGES(2)) u_rst (
    .clk_i   (clk_i),
    .rst_n_i (rst_n_i),
    .rst_n_o (rst_n_s)
  );

  slp_entry_dec u_ent (
    .wfi_req_i         (wfi_req_i),
    .wfe_req_i         (wfe_req_i),
    .exc_ret_i         (exc_ret_i),
    .deep_sel_i        (deep_sel_i),
    .sleep_after_isr_i (sleep_after_isr_i),
    .irq_pend_any_i    (|irq_en_pend_i),
    .evt_pend_any_i    (|wake_evt_i),
    .enter_o           (enter),
    .cause_o           (ent_cause)
  );

  slp_wake_sel #(.N_IRQ(N_IRQ), .N_EVT(N_EVT)) u_wake (
    .clk_i           (clk_i),
    .rst_n_i         (rst_n_s),
    .cause_i         (cause_q),
    .wake_any_pend_i (wake_any_pend_i),
    .irq_en_pend_i   (irq_en_pend_i),
    .irq_dis_pend_i  (irq_dis_pend_i),
    .wake_evt_i      (wake_evt_i),
    .wake_o          (wake),
    .rsn_o           (wake_rsn)
  );

  assign asleep = mode_q[MODE_SLEEP_BIT];
  assign in_lp  = mode_q[MODE_LP_BIT];

  slp_pin_hold #(.W(N_PIN)) u_pins (
    .clk_i   (clk_i),
    .rst_n_i (rst_n_s),
    .ld_i    (!asleep),
    .d_i     (pin_d_i),
    .q_o     (pin_q_o)
  );

  always_comb begin
    mode_n   = mode_q;
    cause_n  = cause_q;
    clk_en_n = clk_en_q;
    rsn_n    = RSN_NONE;
    if (asleep) begin
      if (wake) begin
        mode_n   = in_lp ? MODE_LPRUN : MODE_RUN;
        cause_n  = CAUSE_NONE;
        clk_en_n = 1'b1;
        rsn_n    = wake_rsn;
      end
    end else if (enter) begin
      mode_n   = in_lp ? MODE_LPSLEEP : MODE_SLEEP;
      cause_n  = ent_cause;
      clk_en_n = 1'b0;
    end else begin
      mode_n   = lp_run_i ? MODE_LPRUN : MODE_RUN;
      cause_n  = CAUSE_NONE;
      clk_en_n = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_n_s) begin
    if (!rst_n_s) begin
      mode_q   <= MODE_RUN;
      cause_q  <= CAUSE_NONE;
      clk_en_q <= 1'b1;
      rsn_q    <= RSN_NONE;
    end else begin
      mode_q   <= mode_n;
      cause_q  <= cause_n;
      clk_en_q <= clk_en_n;
      rsn_q    <= rsn_n;
    end
  end

  assign mode_o     = mode_q;
  assign cause_o    = cause_q;
  assign clk_en_o   = clk_en_q;
  assign wake_rsn_o = rsn_q;
endmodule

// File: rtl/sleep_seq_chk.sv
module sleep_seq_chk #(
  parameter int N_IRQ = 16,
  parameter int N_EVT = 8,
  parameter int N_PIN = 8
) (
  input logic             clk_i,
  input logic             rst_n_i,
  input logic             deep_sel_i,
  input logic             wake_any_pend_i,
  input logic [N_IRQ-1:0] irq_en_pend_i,
  input logic [N_EVT-1:0] wake_evt_i,
  input logic [1:0]       mode_o,
  input logic             clk_en_o,
  input logic [1:0]       cause_o,
  input logic [1:0]       wake_rsn_o,
  input logic [N_PIN-1:0] pin_q_o
);
  p_deep_blocks_r1: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (!mode_o[0] && deep_sel_i) |=> !mode_o[0]);

  p_irq_only_r4: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (mode_o[0] && (cause_o == 2'd1 || cause_o == 2'd3) && irq_en_pend_i == '0) |=> mode_o[0]);

  p_evt_only_r5: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (mode_o[0] && cause_o == 2'd2 && !wake_any_pend_i && wake_evt_i == '0) |=> mode_o[0]);

  p_lp_entry_r7: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (mode_o == 2'd2) ##1 mode_o[0] |-> mode_o == 2'd3);

  p_lp_return_r7: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (mode_o == 2'd3) ##1 !mode_o[0] |-> mode_o == 2'd2);

  p_gate_r8: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    clk_en_o == !mode_o[0]);

  p_rsn_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (wake_rsn_o != 2'd0) |=> wake_rsn_o == 2'd0);

  p_pin_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    mode_o[0] |=> $stable(pin_q_o));

  p_cause_r10: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    mode_o[0] == (cause_o != 2'd0));
endmodule

bind sleep_seq_top sleep_seq_chk #(.N_IRQ(N_IRQ), .N_EVT(N_EVT), .N_PIN(N_PIN)) u_chk (
  .clk_i           (clk_i),
  .rst_n_i         (rst_n_i),
  .deep_sel_i      (deep_sel_i),
  .wake_any_pend_i (wake_any_pend_i),
  .irq_en_pend_i   (irq_en_pend_i),
  .wake_evt_i      (wake_evt_i),
  .mode_o          (mode_o),
  .clk_en_o        (clk_en_o),
  .cause_o         (cause_o),
  .wake_rsn_o      (wake_rsn_o),
  .pin_q_o         (pin_q_o)
);

// File: tb/tb_sleep_seq_top.sv
module tb_sleep_seq_top;
  localparam int N_IRQ = 16;
  localparam int N_EVT = 8;
  localparam int N_PIN = 8;

  logic clk = 1'b0;
  logic rst_n;
  logic wfi, wfe, exc_ret, deep, soe, anyp, lp;
  logic [N_IRQ-1:0] irq_en, irq_dis;
  logic [N_EVT-1:0] evt;
  logic [N_PIN-1:0] pin_d;
  logic [1:0] mode, cause, rsn;
  logic clk_en;
  logic [N_PIN-1:0] pin_q;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10ns clk = ~clk;

  sleep_seq_top #(.N_IRQ(N_IRQ), .N_EVT(N_EVT), .N_PIN(N_PIN)) dut (
    .clk_i(clk), .rst_n_i(rst_n), .wfi_req_i(wfi), .wfe_req_i(wfe),
    .exc_ret_i(exc_ret), .deep_sel_i(deep), .sleep_after_isr_i(soe),
    .wake_any_pend_i(anyp), .lp_run_i(lp), .irq_en_pend_i(irq_en),
    .irq_dis_pend_i(irq_dis), .wake_evt_i(evt), .pin_d_i(pin_d),
    .mode_o(mode), .clk_en_o(clk_en), .cause_o(cause),
    .wake_rsn_o(rsn), .pin_q_o(pin_q)
  );

  typedef struct {
    logic [1:0]       m;
    logic [1:0]       c;
    logic             ce;
    logic [1:0]       r;
    logic [N_PIN-1:0] pin;
    string            tag;
  } exp_t;

  exp_t sb[$];
  logic [1:0]       prev_m;
  logic [N_PIN-1:0] exp_pin;

  // Driver: inputs are already set for this cycle; queue the outcome after the next edge.
  task automatic tick(input logic [1:0] m, input logic [1:0] c, input logic ce,
                      input logic [1:0] r, input string tag);
    exp_t e;
    e.m = m; e.c = c; e.ce = ce; e.r = r; e.tag = tag;
    e.pin = prev_m[0] ? exp_pin : pin_d;   // R9: load outside sleep, hold inside
    exp_pin = e.pin;
    prev_m = m;
    sb.push_back(e);
    @(negedge clk);
  endtask

  // Monitor: compares 5 ns after each rising edge.
  initial begin
    forever begin
      @(posedge clk);
      #5ns;
      while (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        checks++;
        if (mode !== e.m || cause !== e.c || clk_en !== e.ce || rsn !== e.r || pin_q !== e.pin) begin
          errors++;
          $display("FAIL %s: got mode=%0d cause=%0d clk_en=%0b rsn=%0d pin=%h, expected mode=%0d cause=%0d clk_en=%0b rsn=%0d pin=%h",
                   e.tag, mode, cause, clk_en, rsn, pin_q, e.m, e.c, e.ce, e.r, e.pin);
        end
      end
    end
  end

  initial begin
    #(200000 * 20ns);
    errors++;
    checks++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    wfi = 0; wfe = 0; exc_ret = 0; deep = 0; soe = 0; anyp = 0; lp = 0;
    irq_en = '0; irq_dis = '0; evt = '0; pin_d = 8'hA5;
    prev_m = 2'd0; exp_pin = '0;
    repeat (3) @(negedge clk);
    checks++;
    if (mode !== 2'd0 || cause !== 2'd0 || rsn !== 2'd0 || clk_en !== 1'b1 || pin_q !== '0) begin
      errors++;
      $display("FAIL R12: got mode=%0d cause=%0d rsn=%0d clk_en=%0b pin=%h, expected 0 0 0 1 00",
               mode, cause, rsn, clk_en, pin_q);
    end
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    tick(2'd0, 2'd0, 1, 2'd0, "R12");

    // R1: deep-sleep select blocks every request
    deep = 1; wfi = 1; tick(2'd0, 2'd0, 1, 2'd0, "R1");
    wfi = 0; exc_ret = 1; soe = 1; tick(2'd0, 2'd0, 1, 2'd0, "R1");
    deep = 0; exc_ret = 0; soe = 0;

    // R2: refusal while pending
    irq_en = 16'h0008; wfi = 1; tick(2'd0, 2'd0, 1, 2'd0, "R2");
    irq_en = '0; wfi = 0; evt = 8'h01; wfe = 1; tick(2'd0, 2'd0, 1, 2'd0, "R2");
    evt = '0; wfe = 0;

    // R11 / R10: simultaneous requests record WFI
    wfi = 1; wfe = 1; tick(2'd1, 2'd1, 0, 2'd0, "R11");
    wfi = 0; wfe = 0; evt = 8'h01; pin_d = 8'h3C; tick(2'd1, 2'd1, 0, 2'd0, "R4/R9");
    evt = '0; irq_dis = 16'h0004; tick(2'd1, 2'd1, 0, 2'd0, "R4");
    irq_dis = '0; irq_en = 16'h0020; tick(2'd0, 2'd0, 1, 2'd1, "R8");
    irq_en = '0; tick(2'd0, 2'd0, 1, 2'd0, "R8");

    // R5: WFE, wake-on-any-pend clear
    wfe = 1; tick(2'd1, 2'd2, 0, 2'd0, "R10");
    wfe = 0; irq_en = 16'h0001; tick(2'd1, 2'd2, 0, 2'd0, "R5");
    irq_en = '0; evt = 8'h02; tick(2'd0, 2'd0, 1, 2'd2, "R5");
    evt = '0;

    // R6: WFE, wake-on-any-pend set
    anyp = 1; wfe = 1; tick(2'd1, 2'd2, 0, 2'd0, "R6");
    wfe = 0; irq_dis = 16'h0001; tick(2'd0, 2'd0, 1, 2'd1, "R6");
    irq_dis = '0; tick(2'd0, 2'd0, 1, 2'd0, "R6");
    wfe = 1; tick(2'd1, 2'd2, 0, 2'd0, "R6");
    wfe = 0; evt = 8'h80; tick(2'd0, 2'd0, 1, 2'd2, "R6");
    evt = '0; anyp = 0;

    // R3: exception return
    exc_ret = 1; soe = 1; irq_en = 16'h0100; tick(2'd0, 2'd0, 1, 2'd0, "R3");
    irq_en = '0; tick(2'd1, 2'd3, 0, 2'd0, "R3");
    exc_ret = 0; evt = 8'h04; tick(2'd1, 2'd3, 0, 2'd0, "R4");
    evt = '0; irq_en = 16'h0100; tick(2'd0, 2'd0, 1, 2'd1, "R4");
    irq_en = '0; soe = 0;

    // R7: low-power pairing
    lp = 1; tick(2'd2, 2'd0, 1, 2'd0, "R7");
    wfi = 1; tick(2'd3, 2'd1, 0, 2'd0, "R7");
    wfi = 0; lp = 0; pin_d = 8'h5A; tick(2'd3, 2'd1, 0, 2'd0, "R7/R9");
    irq_en = 16'h8000; tick(2'd2, 2'd0, 1, 2'd1, "R7");
    irq_en = '0; tick(2'd0, 2'd0, 1, 2'd0, "R7");

    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule